// File: doc/BRIEF.md
# Half-Bridge Dead-Time Pulse Generator

This block drives the two gates of a lamp half-bridge. While enabled it produces alternating high-side and low-side pulses of equal width. A dead-time, in which both gates are off, sits between every pair of pulses. The on-time comes from one of two programmable counts: a short one for filament preheat and a longer one for steady running. During ignition the on-time moves from the preheat count to the run count one step at a time, so the switching frequency sweeps down smoothly instead of jumping.

A sequencer upstream supplies the enable and the operating mode. Each pulse train starts on the low side, so the bootstrap supply of the high-side driver is charged before the high side is driven. Dropping the enable, for lockout or a fault, turns both gates off at once and resets the cycle. A one-clock strobe marks the end of each low-side pulse, and a window signal covers the whole low-side pulse. An over-current counter downstream uses both.

Top module: `hb_pulse_gen`

## Requirements
- R1: While reset is asserted, or one clock edge after `drive_en` is sampled low, `gate_hi`, `gate_lo`, `lo_end_stb` and `oc_window` are all 0, and the cycle state returns to idle.
- R2: The first edge that samples `drive_en` high after idle makes `gate_lo` go high. `gate_hi` never rises before the first low-side pulse of a train.
- R3: While enabled, the outputs repeat this order: low-side pulse, dead-time, high-side pulse, dead-time.
- R4: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R5: Each dead-time lasts `dead_cnt` clock cycles with both gates low. A value of 0 acts as 1.
- R6: The on-time is latched when a low-side pulse starts, and the high-side pulse that follows uses the same width. An on-time value of 0 acts as 1.
- R7: When `op_mode` = 0 (preheat), each pulse lasts `preheat_ton` cycles.
- R8: When `op_mode` = 1 (ignition), the on-time starts at the preheat value. Every RAMP_DIV clocks it moves one count toward `run_ton`, so pulse widths change monotonically and settle at `run_ton`.
- R9: When `op_mode` = 2 or 3 (run), each pulse lasts `run_ton` cycles.
- R10: `lo_end_stb` is high only in the last cycle of each low-side pulse, once per pulse. `oc_window` is high exactly while `gate_lo` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | Enable from the sequencer; low forces the gates off |
| op_mode | input | 2 | 0 preheat, 1 ignition, 2 or 3 run |
| preheat_ton | input | CW | Preheat on-time in clocks |
| run_ton | input | CW | Run on-time in clocks |
| dead_cnt | input | CW | Dead-time in clocks |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| lo_end_stb | output | 1 | One-clock strobe in the last cycle of a low-side pulse |
| oc_window | output | 1 | High during the low-side on-time |

## Verification
The ramp-step assertion assumes that `run_ton` is held steady while ignition runs, and the model comparison assumes that count inputs change only between clock edges. The stimulus changes counts and mode only on falling clock edges. It changes counts only while preheat is active or the block is disabled, never in the middle of a ramp. Zero counts are applied only in a separate scenario that checks the clamp to one cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LO   = 3'd1,
      PH_DA   = 3'd2,
      PH_HI   = 3'd3,
      PH_DB   = 3'd4
   } hb_phase_e;

   localparam logic [1:0] MD_PRE = 2'd0;
   localparam logic [1:0] MD_IGN = 2'd1;

endpackage

// File: rtl/hb_ontime_ramp.sv
module hb_ontime_ramp
   import hb_pkg::*;
#(
   parameter int CW       = 8,
   parameter int RAMP_DIV = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] ph_on,
   input  logic [CW-1:0] run_on,
   output logic [CW-1:0] cur
);

   localparam int DW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;

   logic ign;
   logic step;
   logic [CW-1:0] cur_q;

   assign ign = en && (mode == MD_IGN);

   generate
      if (RAMP_DIV <= 1) begin : g_nodiv
         assign step = 1'b1;
      end else begin : g_div
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         div_q <= '0;
            else if (!ign)                      div_q <= '0;
            else if (div_q == DW'(RAMP_DIV-1))  div_q <= '0;
            else                                div_q <= div_q + DW'(1);
         end
         assign step = (div_q == DW'(RAMP_DIV-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cur_q <= '0;
      else if (!en || mode == MD_PRE)    cur_q <= ph_on;
      else if (mode[1])                  cur_q <= run_on;
      else if (ign && step) begin
         if (cur_q < run_on)             cur_q <= cur_q + CW'(1);
         else if (cur_q > run_on)        cur_q <= cur_q - CW'(1);
      end
   end

   assign cur = cur_q;

   // R8: within ignition the on-time moves by at most one count per clock
   assert_ramp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ign && $past(ign) && $stable(run_on)) |->
         ((cur_q == $past(cur_q)) || (cur_q == $past(cur_q) + CW'(1)) ||
          (cur_q == $past(cur_q) - CW'(1))));

endmodule

// File: rtl/hb_phase_seq.sv
module hb_phase_seq
   import hb_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [CW-1:0] ton_in,
   input  logic [CW-1:0] dead,
   output hb_phase_e     phase,
   output logic          last
);

   hb_phase_e     phase_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] tlat_q;
   logic [CW-1:0] ton_eff;
   logic [CW-1:0] dead_eff;

   assign ton_eff  = (ton_in == '0) ? CW'(1) : ton_in;
   assign dead_eff = (dead   == '0) ? CW'(1) : dead;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         tlat_q  <= CW'(1);
      end else if (!en) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (phase_q == PH_IDLE || (phase_q == PH_DB && cnt_q == '0)) begin
         phase_q <= PH_LO;
         cnt_q   <= ton_eff - CW'(1);
         tlat_q  <= ton_eff;
      end else if (cnt_q != '0) begin
         cnt_q   <= cnt_q - CW'(1);
      end else begin
         case (phase_q)
            PH_LO: begin
               phase_q <= PH_DA;
               cnt_q   <= dead_eff - CW'(1);
            end
            PH_DA: begin
               phase_q <= PH_HI;
               cnt_q   <= tlat_q - CW'(1);
            end
            PH_HI: begin
               phase_q <= PH_DB;
               cnt_q   <= dead_eff - CW'(1);
            end
            default: begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign phase = phase_q;
   assign last  = (cnt_q == '0);

   // R1: a sampled low enable returns the sequence to idle
   assert_disable_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase_q == PH_IDLE));

   // R2: idle is never followed directly by a high-side pulse
   assert_low_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |=> (phase_q != PH_HI));

endmodule

// File: rtl/hb_pulse_gen.sv
module hb_pulse_gen
   import hb_pkg::*;
#(
   parameter int CW       = 8,
   parameter int RAMP_DIV = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          drive_en,
   input  logic [1:0]    op_mode,
   input  logic [CW-1:0] preheat_ton,
   input  logic [CW-1:0] run_ton,
   input  logic [CW-1:0] dead_cnt,
   output logic          gate_hi,
   output logic          gate_lo,
   output logic          lo_end_stb,
   output logic          oc_window
);

   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("hb_pulse_gen: CW must lie in 2..16");
      end
      if (RAMP_DIV < 1) begin : g_bad_div
         $error("hb_pulse_gen: RAMP_DIV must be at least 1");
      end
   endgenerate

   logic [CW-1:0] ton_cur;
   hb_phase_e     phase;
   logic          last;

   hb_ontime_ramp #(.CW(CW), .RAMP_DIV(RAMP_DIV)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (drive_en),
      .mode   (op_mode),
      .ph_on  (preheat_ton),
      .run_on (run_ton),
      .cur    (ton_cur)
   );

   hb_phase_seq #(.CW(CW)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (drive_en),
      .ton_in (ton_cur),
      .dead   (dead_cnt),
      .phase  (phase),
      .last   (last)
   );

   assign gate_lo    = (phase == PH_LO);
   assign gate_hi    = (phase == PH_HI);
   assign oc_window  = gate_lo;
   assign lo_end_stb = gate_lo && last;

   // R4: the two gates are never on together
   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   // R5: each gate turn-off is followed by a cycle with the other gate off
   assert_dead_after_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_lo) |-> !gate_hi);
   assert_dead_after_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_hi) |-> !gate_lo);

   // R10: the strobe closes the low-side pulse
   assert_strobe_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lo_end_stb |=> !gate_lo);

endmodule

// File: tb/hb_pulse_gen_bench.sv
module hb_pulse_gen_bench;

   localparam int CW       = 8;
   localparam int RAMP_DIV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          drive_en = 1'b0;
   logic [1:0]    op_mode = 2'd0;
   logic [CW-1:0] preheat_ton = '0;
   logic [CW-1:0] run_ton = '0;
   logic [CW-1:0] dead_cnt = '0;
   logic          gate_hi, gate_lo, lo_end_stb, oc_window;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hb_pulse_gen #(.CW(CW), .RAMP_DIV(RAMP_DIV)) u_hb_pulse_gen (
      .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .op_mode(op_mode),
      .preheat_ton(preheat_ton), .run_ton(run_ton), .dead_cnt(dead_cnt),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .lo_end_stb(lo_end_stb),
      .oc_window(oc_window)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model: 0 idle, 1 low pulse, 2 dead, 3 high pulse, 4 dead
   int m_ph = 0, m_cnt = 0, m_tl = 1, m_cur = 0, m_div = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_tl = 1; m_cur = 0; m_div = 0;
      end else begin
         int ton, de, ncur;
         bit stp;
         ton = (m_cur == 0) ? 1 : m_cur;
         de  = (dead_cnt == 0) ? 1 : int'(dead_cnt);
         stp = 1'b0;
         if (drive_en && op_mode == 2'd1) begin
            if (m_div == RAMP_DIV-1) begin stp = 1'b1; m_div = 0; end
            else m_div++;
         end else m_div = 0;
         if (!drive_en || op_mode == 2'd0)        ncur = preheat_ton;
         else if (op_mode >= 2'd2)                ncur = run_ton;
         else if (stp && m_cur < int'(run_ton))   ncur = m_cur + 1;
         else if (stp && m_cur > int'(run_ton))   ncur = m_cur - 1;
         else                                     ncur = m_cur;
         if (!drive_en) begin m_ph = 0; m_cnt = 0; end
         else if (m_ph == 0 || (m_ph == 4 && m_cnt == 0)) begin
            m_ph = 1; m_cnt = ton - 1; m_tl = ton;
         end
         else if (m_cnt > 0) m_cnt--;
         else if (m_ph == 1) begin m_ph = 2; m_cnt = de - 1; end
         else if (m_ph == 2) begin m_ph = 3; m_cnt = m_tl - 1; end
         else begin m_ph = 4; m_cnt = de - 1; end
         m_cur = ncur;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(gate_lo == (m_ph == 1) && gate_hi == (m_ph == 3), "R3 gates vs model",
             {gate_hi, gate_lo}, {(m_ph == 3), (m_ph == 1)});
         chk(lo_end_stb == (m_ph == 1 && m_cnt == 0) && oc_window == (m_ph == 1),
             "R10 strobe/window vs model", {lo_end_stb, oc_window},
             {(m_ph == 1 && m_cnt == 0), (m_ph == 1)});
         chk(!(gate_hi && gate_lo), "R4 no overlap", {gate_hi, gate_lo}, 0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic bit sig(input int w);
      return (w == 0) ? gate_lo : gate_hi;
   endfunction

   task automatic wait_rise(input int w);
      while (sig(w))  @(negedge clk);
      while (!sig(w)) @(negedge clk);
   endtask

   task automatic pair(output int wl, output int gap, output int wh,
                       output int nstb, output bit stb_last);
      wait_rise(0);
      wl = 0; nstb = 0; stb_last = 1'b0;
      while (gate_lo) begin
         wl++;
         if (lo_end_stb) nstb++;
         stb_last = lo_end_stb;
         @(negedge clk);
      end
      gap = 0;
      while (!gate_lo && !gate_hi) begin gap++; @(negedge clk); end
      wh = 0;
      while (gate_hi) begin wh++; @(negedge clk); end
   endtask

   initial begin
      int wl, gap, wh, nstb, prev;
      bit sl;
      repeat (3) @(negedge clk);
      chk(!gate_hi && !gate_lo && !lo_end_stb && !oc_window, "R1 reset outputs",
          {gate_hi, gate_lo, lo_end_stb, oc_window}, 0);
      rst_n = 1'b1;
      preheat_ton = 8'd5; run_ton = 8'd9; dead_cnt = 8'd2; op_mode = 2'd0;
      @(negedge clk);
      drive_en = 1'b1;
      @(negedge clk);
      chk(gate_lo && !gate_hi, "R2 first pulse low side", {gate_hi, gate_lo}, 1);

      pair(wl, gap, wh, nstb, sl);
      chk(wl == 5, "R7 preheat low width", wl, 5);
      chk(gap == 2, "R5 dead width", gap, 2);
      chk(wh == 5, "R3 high width", wh, 5);
      chk(nstb == 1 && sl, "R10 one strobe at last cycle", nstb, 1);

      op_mode = 2'd2;
      repeat (2) @(negedge clk);
      pair(wl, gap, wh, nstb, sl);
      chk(wl == 9, "R9 run low width", wl, 9);
      chk(wh == 9, "R6 high equals low", wh, 9);

      op_mode = 2'd0; preheat_ton = 8'd4; run_ton = 8'd12; dead_cnt = 8'd1;
      repeat (3) @(negedge clk);
      pair(wl, gap, wh, nstb, sl);
      chk(wl == 4, "R7 preheat low width", wl, 4);
      chk(gap == 1, "R5 dead width one", gap, 1);
      op_mode = 2'd1;
      prev = 4;
      for (int i = 0; i < 8; i++) begin
         pair(wl, gap, wh, nstb, sl);
         chk(wl >= prev && wl <= 12, "R8 monotonic ramp", wl, prev);
         chk(wh == wl, "R6 pair equal in ramp", wh, wl);
         prev = wl;
      end
      repeat (40) @(negedge clk);
      pair(wl, gap, wh, nstb, sl);
      chk(wl == 12, "R8 ramp settles at run", wl, 12);

      wait_rise(1);
      drive_en = 1'b0;
      @(negedge clk);
      chk(!gate_hi && !gate_lo && !lo_end_stb && !oc_window, "R1 disable forces low",
          {gate_hi, gate_lo, lo_end_stb, oc_window}, 0);
      repeat (3) @(negedge clk);
      op_mode = 2'd3; run_ton = 8'd7;
      drive_en = 1'b1;
      @(negedge clk);
      chk(gate_lo && !gate_hi, "R2 restart on low side", {gate_hi, gate_lo}, 1);
      pair(wl, gap, wh, nstb, sl);
      chk(wl == 7, "R9 run width mode 3", wl, 7);

      drive_en = 1'b0;
      preheat_ton = 8'd0; run_ton = 8'd0; dead_cnt = 8'd0; op_mode = 2'd0;
      repeat (2) @(negedge clk);
      drive_en = 1'b1;
      pair(wl, gap, wh, nstb, sl);
      chk(wl == 1 && wh == 1, "R6 zero on-time acts as one", wl, 1);
      chk(gap == 1, "R5 zero dead acts as one", gap, 1);

      drive_en = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule